// File: doc/BRIEF.md
# Boundary Shift Crosstalk-Avoiding Bus Codec

This block moves a narrow data word across a long on-chip bus without ever letting two neighbouring wires switch in opposite directions, while still letting the receiving end repair any single corrupted wire. The sending half copies each data bit onto a pair of adjacent wires and adds one even-parity wire. On every second accepted word it sends the whole codeword circularly shifted by one wire. An unshifted word can only have neighbours that differ at odd wire indices, and a shifted word can only have them at even indices. Two successive words therefore never share such a spot, so no adjacent pair can swing in opposite directions between them.

The receiving half keeps a phase bit that follows the same alternation. A row of 2:1 multiplexers undoes the shift, and the data is then recovered from the duplicated pairs. The parity of the even-indexed copies is compared with the parity wire. On a match those copies are used; otherwise the odd-indexed copies are used. Both halves register their outputs, have a valid strobe, and share an active-low reset. In normal use the encoder output drives the long wires and the decoder input sits at the far end.

Top module: `bsc_codec`

## Requirements
- R1: While rst_n is low and in the first cycle after it, line_valid, line_word, dst_valid and dst_data are all zero, and both phase trackers start in the unshifted phase.
- R2: An unshifted codeword places data bit k on wires 2k and 2k+1 and the XOR of all data bits on the top wire 2*DATA_W. Data 4'b0101 gives 9'b000110011, and 4'b0001 gives 9'b100000011.
- R3: A shifted codeword moves the unshifted wire i to wire i+1 and moves the top (parity) wire to wire 0. Data 4'b0001 gives 9'b000000111.
- R4: line_valid is high exactly in the cycle after src_valid is high, and line_word then carries that word's code. When src_valid is low, line_valid falls and line_word keeps its last value.
- R5: Only accepted words advance the phase. Word 0 after reset is unshifted, word 1 is shifted, and so on, whatever idle cycles fall between them. The decoder phase advances by the same rule on sink_valid.
- R6: Between any two successive valid codewords on line_word, no two adjacent wires switch in opposite directions.
- R7: dst_valid is high exactly in the cycle after sink_valid is high, and dst_data then holds the recovered data. With no sink_valid, dst_valid falls and dst_data keeps its value.
- R8: If any one wire of a codeword is inverted between line_word and sink_word, in either phase and including the parity wire, dst_data still equals the data that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low reset |
| src_valid | input | 1 | A word to encode is present |
| src_data | input | DATA_W | Word to encode |
| line_valid | output | 1 | Encoded word on line_word is new this cycle |
| line_word | output | 2*DATA_W+1 | Bus wires driven by the encoder |
| sink_valid | input | 1 | Received wires carry a new codeword |
| sink_word | input | 2*DATA_W+1 | Bus wires seen by the decoder |
| dst_valid | output | 1 | Recovered word is new this cycle |
| dst_data | output | DATA_W | Recovered word |

## Verification
The bench builds the codec with its default 4-bit data width and therefore a 9-wire bus. At that size all 16 data values can be crossed with a flip on each of the 9 wires, in both phases, so every single-error case is covered. It can also check the literal example codewords directly. The encoder output is looped back to the decoder input through a per-word inversion mask. Idle gaps and back-to-back streams then exercise the phase alternation and the opposite-switching rule on real successive words.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic {
      PH_PLAIN = 1'b0,
      PH_ROT   = 1'b1
   } bsc_phase_e;

   function automatic int bsc_bus_width(input int data_w);
      return 2 * data_w + 1;
   endfunction

endpackage

// File: rtl/bsc_phase.sv
module bsc_phase
   import bsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       advance,
   output bsc_phase_e phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= PH_PLAIN;
      else if (advance)
         phase <= (phase == PH_PLAIN) ? PH_ROT : PH_PLAIN;
   end

endmodule

// File: rtl/bsc_encoder.sv
module bsc_encoder
   import bsc_pkg::*;
#(
   parameter  int DATA_W = 4,
   localparam int BUS_W  = 2 * DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [BUS_W-1:0]  out_word
);

   bsc_phase_e         phase;
   logic [BUS_W-1:0]   plain_w;
   logic [BUS_W-1:0]   rot_w;

   bsc_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (in_valid),
      .phase   (phase)
   );

   for (genvar k = 0; k < DATA_W; k++) begin : g_dup
      assign plain_w[2*k]   = in_data[k];
      assign plain_w[2*k+1] = in_data[k];
   end
   assign plain_w[BUS_W-1] = ^in_data;

   assign rot_w[0] = plain_w[BUS_W-1];
   for (genvar i = 1; i < BUS_W; i++) begin : g_rot
      assign rot_w[i] = plain_w[i-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_word <= (phase == PH_ROT) ? rot_w : plain_w;
      end
   end

endmodule

// File: rtl/bsc_decoder.sv
module bsc_decoder
   import bsc_pkg::*;
#(
   parameter  int DATA_W = 4,
   localparam int BUS_W  = 2 * DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BUS_W-1:0]  in_word,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   bsc_phase_e          phase;
   logic [BUS_W-1:0]    plain_w;
   logic [DATA_W-1:0]   copy_even;
   logic [DATA_W-1:0]   copy_odd;
   logic                even_ok;
   logic [DATA_W-1:0]   fixed;

   bsc_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (in_valid),
      .phase   (phase)
   );

   // one 2:1 mux per wire undoes the alternate-word shift
   for (genvar i = 0; i < BUS_W; i++) begin : g_unrot
      if (i == BUS_W - 1) begin : g_top
         assign plain_w[i] = (phase == PH_ROT) ? in_word[0] : in_word[i];
      end else begin : g_low
         assign plain_w[i] = (phase == PH_ROT) ? in_word[i+1] : in_word[i];
      end
   end

   for (genvar k = 0; k < DATA_W; k++) begin : g_split
      assign copy_even[k] = plain_w[2*k];
      assign copy_odd[k]  = plain_w[2*k+1];
   end

   assign even_ok = ((^copy_even) == plain_w[BUS_W-1]);
   assign fixed   = even_ok ? copy_even : copy_odd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= fixed;
      end
   end

endmodule

// File: rtl/bsc_codec.sv
module bsc_codec
   import bsc_pkg::*;
#(
   parameter  int DATA_W = 4,
   localparam int BUS_W  = 2 * DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              line_valid,
   output logic [BUS_W-1:0]  line_word,
   input  logic              sink_valid,
   input  logic [BUS_W-1:0]  sink_word,
   output logic              dst_valid,
   output logic [DATA_W-1:0] dst_data
);

   if (DATA_W < 1) begin : g_bad_width
      $error("bsc_codec: DATA_W must be at least 1");
   end
   if (BUS_W != bsc_bus_width(DATA_W)) begin : g_bad_bus
      $error("bsc_codec: bus width mismatch");
   end

   bsc_encoder #(.DATA_W(DATA_W)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (src_valid),
      .in_data   (src_data),
      .out_valid (line_valid),
      .out_word  (line_word)
   );

   bsc_decoder #(.DATA_W(DATA_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (sink_valid),
      .in_word   (sink_word),
      .out_valid (dst_valid),
      .out_data  (dst_data)
   );

endmodule

// File: rtl/bsc_codec_chk.sv
module bsc_codec_chk #(
   parameter  int DATA_W = 4,
   localparam int BUS_W  = 2 * DATA_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_valid,
   input logic [DATA_W-1:0] src_data,
   input logic              line_valid,
   input logic [BUS_W-1:0]  line_word,
   input logic              sink_valid,
   input logic              dst_valid,
   input logic [DATA_W-1:0] dst_data
);

   logic [BUS_W-1:0] last_word;
   logic             have_last;
   logic [BUS_W-1:0] rise;
   logic [BUS_W-1:0] fall;
   logic [BUS_W-2:0] clash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_word <= '0;
         have_last <= 1'b0;
      end else if (line_valid) begin
         last_word <= line_word;
         have_last <= 1'b1;
      end
   end

   assign rise  = ~last_word & line_word;
   assign fall  = last_word & ~line_word;
   assign clash = (rise[BUS_W-2:0] & fall[BUS_W-1:1]) |
                  (fall[BUS_W-2:0] & rise[BUS_W-1:1]);

   // R4
   enc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |=> line_valid);

   // R4
   enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |=> (!line_valid && $stable(line_word)));

   // R2
   enc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |-> ((^line_word) == (^$past(src_data))));

   // R6
   no_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && have_last) |-> (clash == '0));

   // R7
   dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sink_valid |=> dst_valid);

   // R7
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sink_valid |=> (!dst_valid && $stable(dst_data)));

endmodule

bind bsc_codec bsc_codec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_valid  (src_valid),
   .src_data   (src_data),
   .line_valid (line_valid),
   .line_word  (line_word),
   .sink_valid (sink_valid),
   .dst_valid  (dst_valid),
   .dst_data   (dst_data)
);

// File: tb/bsc_codec_tb.sv
module bsc_codec_tb;

   localparam int DW = 4;
   localparam int BW = 2 * DW + 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          src_valid;
   logic [DW-1:0] src_data;
   logic          line_valid;
   logic [BW-1:0] line_word;
   logic [BW-1:0] cur_flip;
   logic          dst_valid;
   logic [DW-1:0] dst_data;

   always #4 clk = ~clk;

   bsc_codec #(.DATA_W(DW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_valid  (src_valid),
      .src_data   (src_data),
      .line_valid (line_valid),
      .line_word  (line_word),
      .sink_valid (line_valid),
      .sink_word  (line_word ^ cur_flip),
      .dst_valid  (dst_valid),
      .dst_data   (dst_data)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench-side expectation of the registered outputs
   logic          m_lv;
   logic [BW-1:0] m_lw;
   logic          m_lph;
   logic [DW-1:0] m_ld;
   logic [BW-1:0] m_lf;
   logic          m_ph;
   logic          m_dv;
   logic [DW-1:0] m_dd;
   logic [BW-1:0] prev_w;
   logic          have_prev;
   logic          lit_en;
   logic [BW-1:0] lit_val;
   string         lit_tag;

   function automatic logic [BW-1:0] ref_code(input logic [DW-1:0] d, input logic ph);
      logic [BW-1:0] w;
      for (int k = 0; k < DW; k++) begin
         w[2*k]   = d[k];
         w[2*k+1] = d[k];
      end
      w[BW-1] = ^d;
      if (ph) w = {w[BW-2:0], w[BW-1]};
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   task automatic expect_line(input string tag, input logic [BW-1:0] val);
      lit_en  = 1'b1;
      lit_val = val;
      lit_tag = tag;
   endtask

   task automatic step(input logic v, input logic [DW-1:0] d, input logic [BW-1:0] f);
      logic [BW-1:0] rs;
      logic [BW-1:0] fl;
      logic [BW-2:0] cl;
      @(negedge clk);
      chk("R4 line_valid", {31'd0, line_valid}, {31'd0, m_lv});
      chk(m_lph ? "R3 line_word" : "R2 line_word", {23'd0, line_word}, {23'd0, m_lw});
      chk("R7 dst_valid", {31'd0, dst_valid}, {31'd0, m_dv});
      chk("R8 dst_data", {28'd0, dst_data}, {28'd0, m_dd});
      if (lit_en) begin
         chk(lit_tag, {23'd0, line_word}, {23'd0, lit_val});
         lit_en = 1'b0;
      end
      if (line_valid) begin
         if (have_prev) begin
            rs = ~prev_w & line_word;
            fl = prev_w & ~line_word;
            cl = (rs[BW-2:0] & fl[BW-1:1]) | (fl[BW-2:0] & rs[BW-1:1]);
            chk("R6 opposite switching", {24'd0, cl}, 32'd0);
         end
         prev_w    = line_word;
         have_prev = 1'b1;
      end
      cur_flip = m_lf;
      m_dv = m_lv;
      if (m_lv) m_dd = m_ld;
      if (v) begin
         m_lw  = ref_code(d, m_ph);
         m_lph = m_ph;
         m_ld  = d;
         m_lf  = f;
         m_ph  = ~m_ph;
      end
      m_lv      = v;
      src_valid = v;
      src_data  = d;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      src_valid = 1'b0;
      src_data = '0;
      cur_flip = '0;
      m_lv = 1'b0; m_lw = '0; m_lph = 1'b0; m_ld = '0; m_lf = '0;
      m_ph = 1'b0; m_dv = 1'b0; m_dd = '0;
      prev_w = '0; have_prev = 1'b0; lit_en = 1'b0; lit_val = '0; lit_tag = "";
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 line_valid", {31'd0, line_valid}, 32'd0);
      chk("R1 line_word", {23'd0, line_word}, 32'd0);
      chk("R1 dst_valid", {31'd0, dst_valid}, 32'd0);
      chk("R1 dst_data", {28'd0, dst_data}, 32'd0);
      rst_n = 1'b1;
   endtask

   // R2 R3 R5: literal codewords, phase kept across idle gaps
   task automatic t_examples();
      step(1'b1, 4'b0101, '0);
      expect_line("R2 R1 first word unshifted 0101", 9'b000110011);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      step(1'b1, 4'b0001, '0);
      expect_line("R3 second word shifted 0001", 9'b000000111);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
      step(1'b1, 4'b0001, '0);
      expect_line("R5 third word unshifted 0001", 9'b100000011);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
   endtask

   // R6 R7: back-to-back stream
   task automatic t_burst();
      for (int i = 0; i < 48; i++) step(1'b1, DW'((i * 7 + 3) % 16), '0);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
   endtask

   // R5: irregular gaps between words
   task automatic t_gaps();
      for (int i = 0; i < 30; i++) step((i % 3) != 1, DW'((i * 5 + 1) % 16), '0);
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
   endtask

   // R8: every data value with every single wire inverted
   task automatic t_errors();
      for (int d = 0; d < 16; d++) begin
         for (int w = 0; w < BW; w++) step(1'b1, DW'(d), BW'(1) << w);
      end
      step(1'b0, '0, '0);
      step(1'b0, '0, '0);
   endtask

   initial begin
      t_reset();
      t_examples();
      t_burst();
      t_gaps();
      t_errors();
      summary();
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule